// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block takes DMA requests from four peripherals and hands the bus to one of them at a time. Each request line passes through a sampling register that can invert it. The block then asserts one acknowledge line, which can also be inverted, for the channel it picks. A channel keeps the grant until it drops its request or a terminal-count pulse arrives for it. A new winner is chosen only while no grant is active. The choice uses either a fixed order, with channel 0 first, or a rotating order in which the channel just served moves to the back.

Software controls the block through a single-beat bus. A write loads an 8-bit command register. A read returns a status byte that holds the sampled requests and a set of sticky terminal-count flags. Reading the status byte clears those flags. Several command bits belong to transfer functions that this block does not perform. They are stored, but they have no effect.

Top module: `dma_req_arbiter`

## Requirements
- R1: Reset clears the command register and every terminal-count flag, and removes any grant. Afterwards all acknowledge lines are low, the read data is 0x00, and the block runs enabled, active-high and with fixed priority.
- R2: Command bit 6 sets the request polarity: 0 means a high input is a request, 1 means a low input is a request. Each request input is sampled through one register before it is used.
- R3: Command bit 7 sets the acknowledge polarity: 0 drives the granted line high and the others low, 1 drives the granted line low and the others high.
- R4: When command bit 4 is 0 (fixed priority), an idle arbiter grants the lowest-numbered channel with a sampled request, in the cycle after that request is sampled.
- R5: When command bit 4 is 1 (rotating priority), the channel after the one whose grant last ended becomes the highest priority, counting modulo 4.
- R6: At most one channel holds a grant. A grant ends in the cycle after its sampled request drops, or after a terminal-count pulse for that channel.
- R7: When command bit 2 is 1, the controller is disabled: no acknowledge line is active, any existing grant is dropped, and no new grant is issued.
- R8: A read strobe captures the status byte, which appears on the read data one cycle later and is held until the next read. Bits 7..4 are the sampled requests of channels 3..0. Bits 3..0 are the terminal-count flags of channels 3..0.
- R9: A terminal-count pulse sets the flag of its channel. A status read clears all flags, but a pulse that arrives in the same cycle as the read leaves its flag set.
- R10: Command bits 5, 3, 1 and 0 are stored but do not change the acknowledge or status behaviour.
- R11: While a grant is active, a new request, even one of higher priority, does not take the grant away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Command register write strobe |
| bus_wdata | input | 8 | Command write data |
| bus_rd | input | 1 | Status read strobe |
| bus_rdata | output | 8 | Status read data, valid the cycle after the strobe |
| dreq_in | input | 4 | Raw DMA request lines, polarity set by command bit 6 |
| tc_in | input | 4 | Active-high terminal-count pulses, one per channel |
| dack_out | output | 4 | DMA acknowledge lines, polarity set by command bit 7 |

## Verification
Two functions can act on the same flop in the same cycle. First, a terminal-count pulse can arrive together with a status read. Second, a terminal-count pulse can end a grant in the same cycle that the request drops, or in the same cycle that a command write disables or re-polarizes the block. Directed phases place a pulse exactly on a read strobe and on the last cycle of a grant. A long random phase then drives strobes, pulses and command writes that collide freely. Each case is judged by comparing the acknowledge lines and the read data, on every clock, against a behavioural model that computes the next state from the previous cycle's values.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;
  // Command byte layout; member order sets bit positions 7 down to 0.
  typedef struct packed {
    logic ack_low;   // 7: acknowledge polarity
    logic req_low;   // 6: request polarity
    logic wr_ext;    // 5: stored only
    logic rotate;    // 4: rotating priority
    logic compress;  // 3: stored only
    logic ctl_off;   // 2: controller disable
    logic hold0;     // 1: stored only
    logic m2m;       // 0: stored only
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);
endpackage

// File: rtl/dmaarb_cmd.sv
module dmaarb_cmd
  import dmaarb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CMD_W-1:0] wdata,
  output cmd_t             cmd_q
);
  always_ff @(posedge clk) begin
    if (rst) cmd_q <= '0;
    else if (wr) cmd_q <= cmd_t'(wdata);
  end
endmodule

// File: rtl/dmaarb_reqin.sv
module dmaarb_reqin #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           invert,
  input  logic [NCH-1:0] raw,
  output logic [NCH-1:0] req_q
);
  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= raw ^ {NCH{invert}};
  end
endmodule

// File: rtl/dmaarb_pick.sv
module dmaarb_pick #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  input  logic [IW-1:0]  base,
  output logic [NCH-1:0] win_oh,
  output logic [IW-1:0]  win_idx
);
  always_comb begin
    logic found;
    found   = 1'b0;
    win_oh  = '0;
    win_idx = '0;
    for (int i = 0; i < NCH; i++) begin
      int ch;
      ch = (int'(base) + i) % NCH;
      if (!found && req[ch]) begin
        found       = 1'b1;
        win_oh[ch]  = 1'b1;
        win_idx     = IW'(ch);
      end
    end
  end
endmodule

// File: rtl/dmaarb_stat.sv
module dmaarb_stat #(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic [NCH-1:0]   tc_in,
  input  logic [NCH-1:0]   req_q,
  output logic [NCH-1:0]   tc_flags,
  output logic [2*NCH-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tc_flags <= '0;
      rdata    <= '0;
    end else begin
      tc_flags <= (rd ? '0 : tc_flags) | tc_in;
      if (rd) rdata <= {req_q, tc_flags};
    end
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dmaarb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [CMD_W-1:0] bus_wdata,
  input  logic             bus_rd,
  output logic [2*NCH-1:0] bus_rdata,
  input  logic [NCH-1:0]   dreq_in,
  input  logic [NCH-1:0]   tc_in,
  output logic [NCH-1:0]   dack_out
);
  cmd_t           cmd_q;
  logic [NCH-1:0] req_q;
  logic [NCH-1:0] tc_flags;
  logic [NCH-1:0] gnt_q;
  logic [IW-1:0]  gidx_q;
  logic [IW-1:0]  base_q;
  logic [NCH-1:0] win_oh;
  logic [IW-1:0]  win_idx;
  logic [IW-1:0]  pick_base;
  logic           active;
  logic           end_now;
  logic [IW-1:0]  next_base;

  dmaarb_cmd u_cmd (
    .clk(clk), .rst(rst), .wr(bus_wr), .wdata(bus_wdata), .cmd_q(cmd_q)
  );

  dmaarb_reqin #(.NCH(NCH)) u_req (
    .clk(clk), .rst(rst), .invert(cmd_q.req_low), .raw(dreq_in), .req_q(req_q)
  );

  dmaarb_pick #(.NCH(NCH)) u_pick (
    .req(req_q), .base(pick_base), .win_oh(win_oh), .win_idx(win_idx)
  );

  dmaarb_stat #(.NCH(NCH)) u_stat (
    .clk(clk), .rst(rst), .rd(bus_rd), .tc_in(tc_in), .req_q(req_q),
    .tc_flags(tc_flags), .rdata(bus_rdata)
  );

  assign pick_base = cmd_q.rotate ? base_q : '0;
  assign active    = |gnt_q;
  assign end_now   = active && (cmd_q.ctl_off || ((req_q & gnt_q) == '0)
                                || ((tc_in & gnt_q) != '0));
  assign next_base = (int'(gidx_q) == NCH - 1) ? '0 : gidx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q  <= '0;
      gidx_q <= '0;
      base_q <= '0;
    end else if (active) begin
      if (end_now) begin
        gnt_q <= '0;
        if (cmd_q.rotate) base_q <= next_base;
      end
    end else if (!cmd_q.ctl_off && (req_q != '0)) begin
      gnt_q  <= win_oh;
      gidx_q <= win_idx;
    end
  end

  assign dack_out = (gnt_q & {NCH{~cmd_q.ctl_off}}) ^ {NCH{cmd_q.ack_low}};
endmodule

// File: rtl/dmaarb_chk.sv
module dmaarb_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [7:0]     cmd_q,
  input logic [NCH-1:0] req_q,
  input logic [NCH-1:0] tc_in,
  input logic [NCH-1:0] gnt_q,
  input logic [NCH-1:0] tc_flags
);
  // R6: never more than one grant
  p_one_grant_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q));

  // R6: a fresh grant needs a sampled request
  p_grant_has_req_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(|gnt_q) |-> ($past(req_q) & gnt_q) != '0);

  // R11: a live grant is not preempted
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    ((gnt_q != '0) && ((req_q & gnt_q) != '0) && ((tc_in & gnt_q) == '0) && !cmd_q[2])
    |=> gnt_q == $past(gnt_q));

  // R7: a disabled controller holds no grant
  p_disable_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_q[2] |=> gnt_q == '0);

  // R4: fixed priority picks the lowest requesting channel
  p_fixed_r4: assert property (@(posedge clk) disable iff (rst)
    ((gnt_q == '0) && !cmd_q[2] && !cmd_q[4] && (req_q != '0))
    |=> gnt_q == $past(req_q & (~req_q + 1'b1)));

  // R9: a pulse always leaves its flag set
  p_tc_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (tc_in != '0) |=> (tc_flags & $past(tc_in)) == $past(tc_in));
endmodule

bind dma_req_arbiter dmaarb_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .cmd_q(cmd_q), .req_q(req_q), .tc_in(tc_in),
  .gnt_q(gnt_q), .tc_flags(tc_flags)
);

// File: tb/sim_dma_req_arbiter.sv
module sim_dma_req_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [3:0] dreq_in = '0;
  logic [3:0] tc_in = '0;
  logic [3:0] dack_out;

  int compared = 0;
  int mismatched = 0;
  string tag = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  dma_req_arbiter u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .dreq_in(dreq_in),
    .tc_in(tc_in), .dack_out(dack_out)
  );

  // Behavioural reference model
  logic [7:0] m_cmd;
  logic [3:0] m_req, m_tc;
  logic [7:0] m_rdata;
  bit         m_act;
  int         m_g, m_base;

  always @(posedge clk) begin
    if (rst) begin
      m_cmd = 0; m_req = 0; m_tc = 0; m_rdata = 0; m_act = 0; m_g = 0; m_base = 0;
    end else begin
      bit en, rot;
      en  = !m_cmd[2];
      rot = m_cmd[4];
      if (m_act) begin
        if (!en || !m_req[m_g] || tc_in[m_g]) begin
          m_act = 0;
          if (rot) m_base = (m_g + 1) % 4;
        end
      end else if (en && m_req != 0) begin
        int start;
        bit got;
        got = 0;
        start = rot ? m_base : 0;
        for (int i = 0; i < 4; i++) begin
          if (!got && m_req[(start + i) % 4]) begin
            got = 1; m_g = (start + i) % 4;
          end
        end
        m_act = 1;
      end
      if (bus_rd) m_rdata = {m_req, m_tc};
      m_tc  = (bus_rd ? 4'b0 : m_tc) | tc_in;
      m_req = dreq_in ^ {4{m_cmd[6]}};
      if (bus_wr) m_cmd = bus_wdata;
    end
  end

  function automatic logic [3:0] exp_dack();
    logic [3:0] g;
    g = (m_act && !m_cmd[2]) ? 4'(1 << m_g) : 4'b0;
    return g ^ {4{m_cmd[7]}};
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (dack_out !== exp_dack()) begin
        mismatched++;
        $display("FAIL %s dack_out actual=%b expected=%b t=%0t", tag, dack_out, exp_dack(), $time);
      end
      compared++;
      if (bus_rdata !== m_rdata) begin
        mismatched++;
        $display("FAIL %s bus_rdata actual=%h expected=%h t=%0t", tag, bus_rdata, m_rdata, $time);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wcmd(logic [7:0] v);
    bus_wr = 1; bus_wdata = v; step(); bus_wr = 0;
  endtask

  task automatic rd_stat();
    bus_rd = 1; step(); bus_rd = 0;
  endtask

  task automatic tc_pulse(logic [3:0] v);
    tc_in = v; step(); tc_in = 0;
  endtask

  initial begin
    step(3);
    tag = "R1"; rst = 0; step(2);
    // R4 fixed priority and R11 no preemption
    tag = "R4"; dreq_in = 4'b1010; step(4);
    tag = "R11"; dreq_in = 4'b1011; step(4);
    tag = "R6"; dreq_in = 4'b1001; step(4);
    tc_pulse(4'b0001); step(3);
    tag = "R9"; rd_stat(); step(2);
    tc_in = 4'b0100; bus_rd = 1; step(); tc_in = 0; bus_rd = 0; step(2);
    rd_stat(); step(2);
    // R5 rotating priority
    tag = "R5"; wcmd(8'h10); dreq_in = 4'b1111; step(3);
    for (int k = 0; k < 6; k++) begin
      tc_pulse(dack_out); step(3);
    end
    // R2 request polarity, R3 acknowledge polarity
    tag = "R2"; dreq_in = 4'b0000; wcmd(8'h40); dreq_in = 4'b1011; step(6);
    tag = "R3"; wcmd(8'hC0); step(6); dreq_in = 4'b1111; step(3);
    // R7 disable
    tag = "R7"; dreq_in = 4'b0000; wcmd(8'h04); step(6); dreq_in = 4'b0110; step(4);
    wcmd(8'h00); step(4);
    // R10 stored-only bits
    tag = "R10"; wcmd(8'h2B); dreq_in = 4'b1100; step(5); dreq_in = 4'b0100; step(4);
    tc_pulse(4'b0100); step(3); rd_stat(); step(2);
    // R8 status layout with random traffic
    tag = "R8";
    for (int k = 0; k < 3000; k++) begin
      dreq_in = 4'($urandom);
      tc_in   = (($urandom % 6) == 0) ? 4'($urandom) : 4'b0;
      bus_rd  = (($urandom % 4) == 0);
      bus_wr  = (($urandom % 40) == 0);
      bus_wdata = 8'($urandom);
      step();
    end
    bus_rd = 0; bus_wr = 0; tc_in = 0; step(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule